// File: doc/BRIEF.md
# I2C Target Port with Event Flags

This block is the target side of an I2C bus. It answers one 7-bit address that software programs, and it can also answer the general-call address. A host processor drives it through a small register port with five registers: control, own address, event flags, event enables and data. The bus side works as open drain. The block samples SCL and SDA through synchronisers and pulls either line low through an output-enable pin. The external bus is the wired AND of every driver.

Each bus event sets its own flag bit in the event register. The events are address match, byte received, byte transmitted, data register empty, STOP, read mode and general call. Software clears a flag by writing 0 to its position. The interrupt line is high while any flag is set and its enable bit is also set.

Received bytes and bytes to send pass through one data register. The block holds SCL low until software has served that register, so software can take as long as it needs. A force-NACK control bit lets software reject incoming data bytes.

Top module: `i2c_tgt`

## Requirements
- R1: After reset all registers read 0, the interrupt is low and neither bus line is driven.
- R2: A write address byte whose upper 7 bits equal the own-address register (register 1, bits 6:0) gets an ACK and sets flag bit 0. A byte with any other address gets no ACK and sets no address flag.
- R3: When a data byte is received, the block sets flag bit 1 and stores the byte in the data register (register 4). SCL is held low until that register is read. Only then is the ACK bit driven.
- R4: While control bit 0 is 1, a received data byte is answered with NACK. The address byte is still acknowledged.
- R5: A read address match sets flag bits 5 and 3 and holds SCL low until the data register is written. The byte is then sent MSB first. Flag bit 3 is set again each time a byte moves out of the data register. Flag bit 2 is set after the 8th bit has been sent.
- R6: After the master answers a sent byte with NACK, the block drives neither SCL nor SDA.
- R7: A STOP seen while the block is enabled sets flag bit 4.
- R8: The flag register is register 2. Writing 0 to a bit position clears that flag. Writing 1 leaves that flag unchanged.
- R9: The interrupt output is the OR, over bits 6:0, of each flag ANDed with the same bit of the enable register (register 3).
- R10: With control bit 1 set, the write address 0x00 gets an ACK and sets flag bits 6 and 0. With control bit 1 clear, that address is ignored.
- R11: With control bit 2 (enable) clear, the block ignores the bus, never drives it and posts no flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (a read of register 4 frees a received byte) |
| reg_addr_i | input | 3 | Register select: 0 control, 1 own address, 2 flags, 3 enables, 4 data |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read data of the selected register |
| irq_o | output | 1 | Interrupt request |
| scl_i | input | 1 | SCL level on the bus |
| sda_i | input | 1 | SDA level on the bus |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |

## Verification
A wrong state in the bit engine shows up at the ports within one bus bit. It appears as an ACK that is missing or comes where none is due, a data bit driven at the wrong value, or SCL that stays low or is released at the wrong moment. The master model in the bench sees this directly on the wired-AND lines. A wrong flag or a wrong full/empty marker in the register file appears on the next register read. It also appears on the interrupt line in the same cycle. It appears at the latest as a stretch that never ends, which the next bus bit exposes.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int REG_AW  = 3;
  localparam int DATA_W  = 8;
  localparam int TADDR_W = 7;
  localparam int FLAG_W  = 7;
  localparam int BIT_CNT_W = $clog2(DATA_W);

  localparam logic [REG_AW-1:0] RA_CTRL = 3'd0;
  localparam logic [REG_AW-1:0] RA_OWN  = 3'd1;
  localparam logic [REG_AW-1:0] RA_FLAG = 3'd2;
  localparam logic [REG_AW-1:0] RA_IEN  = 3'd3;
  localparam logic [REG_AW-1:0] RA_DATA = 3'd4;

  // flag / enable bit positions
  localparam int F_ADDR  = 0;
  localparam int F_RXD   = 1;
  localparam int F_TXD   = 2;
  localparam int F_EMPTY = 3;
  localparam int F_STOP  = 4;
  localparam int F_RDMODE = 5;
  localparam int F_GCALL = 6;

  // control bit positions
  localparam int C_NACK = 0;
  localparam int C_GCEN = 1;
  localparam int C_EN   = 2;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_RX, S_AFALL, S_HOLD, S_AREL, S_ACK,
    S_THOLD, S_TREL, S_TX, S_TACK, S_TWAIT
  } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_filter.sv
module i2c_tgt_filter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw, synced, prev;
  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < LINES; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain <= '1;
      else         chain <= {chain[SYNC_STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain[SYNC_STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev <= '1;
    else         prev <= synced;
  end

  assign sda_o      = synced[1];
  assign scl_rise_o = synced[0] & ~prev[0];
  assign scl_fall_o = ~synced[0] & prev[0];
  assign start_o    = synced[0] & prev[0] & prev[1] & ~synced[1];
  assign stop_o     = synced[0] & prev[0] & ~prev[1] & synced[1];
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 gc_en_i,
  input  logic                 force_nack_i,
  input  logic [TADDR_W-1:0]   own_addr_i,
  input  logic                 sda_i,
  input  logic                 rise_i,
  input  logic                 fall_i,
  input  logic                 start_i,
  input  logic                 stop_i,
  input  logic                 rx_full_i,
  input  logic                 tx_full_i,
  input  logic [DATA_W-1:0]    tx_data_i,
  output logic                 rx_push_o,
  output logic [DATA_W-1:0]    rx_byte_o,
  output logic                 tx_pop_o,
  output logic [FLAG_W-1:0]    set_o,
  output logic                 scl_oe_o,
  output logic                 sda_oe_o
);
  tgt_state_e state;
  logic [DATA_W-1:0]    sh;
  logic [BIT_CNT_W-1:0] cnt;
  logic rw_q, is_addr, ack_q;

  logic act, byte_done, own_hit, gc_hit, addr_hit, tx_last;
  logic [DATA_W-1:0] byte_val;

  always_comb begin
    act       = en_i & ~start_i & ~stop_i;
    byte_val  = {sh[DATA_W-2:0], sda_i};
    byte_done = act & rise_i & (cnt == BIT_CNT_W'(DATA_W-1)) &
                ((state == S_ADDR) | (state == S_RX));
    own_hit   = byte_val[DATA_W-1:1] == own_addr_i;
    gc_hit    = gc_en_i & (byte_val[DATA_W-1:1] == '0) & ~byte_val[0];
    addr_hit  = byte_done & (state == S_ADDR) & (own_hit | gc_hit);
    rx_push_o = byte_done & (state == S_RX);
    rx_byte_o = byte_val;
    tx_pop_o  = act & (state == S_THOLD) & tx_full_i;
    tx_last   = act & (state == S_TX) & fall_i & (cnt == BIT_CNT_W'(DATA_W-1));

    set_o          = '0;
    set_o[F_ADDR]  = addr_hit;
    set_o[F_GCALL] = addr_hit & gc_hit;
    set_o[F_RDMODE] = addr_hit & byte_val[0];
    set_o[F_EMPTY] = (addr_hit & byte_val[0]) | tx_pop_o;
    set_o[F_RXD]   = rx_push_o;
    set_o[F_TXD]   = tx_last;
    set_o[F_STOP]  = en_i & stop_i;

    scl_oe_o = (state == S_HOLD) | (state == S_AREL) |
               (state == S_THOLD) | (state == S_TREL);
    sda_oe_o = (((state == S_AREL) | (state == S_ACK)) & ack_q) |
               (((state == S_TREL) | (state == S_TX)) & ~sh[DATA_W-1]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state <= S_IDLE; sh <= '0; cnt <= '0;
      rw_q <= 1'b0; is_addr <= 1'b0; ack_q <= 1'b0;
    end else if (!en_i || stop_i) begin
      state <= S_IDLE;
    end else if (start_i) begin
      state <= S_ADDR; cnt <= '0;
    end else begin
      unique case (state)
        S_ADDR, S_RX: if (rise_i) begin
          sh  <= byte_val;
          cnt <= cnt + 1'b1;
          if (byte_done) begin
            is_addr <= (state == S_ADDR);
            if (state == S_RX) state <= S_AFALL;
            else if (addr_hit) begin
              rw_q  <= byte_val[0];
              state <= S_AFALL;
            end else state <= S_IDLE;
          end
        end
        S_AFALL: if (fall_i) state <= S_HOLD;
        S_HOLD: if (is_addr || !rx_full_i) begin
          ack_q <= is_addr | ~force_nack_i;
          state <= S_AREL;
        end
        S_AREL: state <= S_ACK;
        S_ACK: if (fall_i) begin
          if (!ack_q)    state <= S_IDLE;
          else if (rw_q) state <= S_THOLD;
          else begin state <= S_RX; cnt <= '0; end
        end
        S_THOLD: if (tx_full_i) begin
          sh <= tx_data_i; state <= S_TREL;
        end
        S_TREL: begin state <= S_TX; cnt <= '0; end
        S_TX: if (fall_i) begin
          sh  <= {sh[DATA_W-2:0], 1'b0};
          cnt <= cnt + 1'b1;
          if (tx_last) state <= S_TACK;
        end
        S_TACK:  if (rise_i) state <= sda_i ? S_IDLE : S_TWAIT;
        S_TWAIT: if (fall_i) state <= S_THOLD;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R3: a received byte not yet read keeps SCL low
  p_stretch_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == S_HOLD && !is_addr && rx_full_i && en_i && !stop_i && !start_i)
      |=> scl_oe_o);
  // R4: the ACK/NACK level does not change inside the acknowledge bit
  p_ack_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == S_ACK && $past(state) == S_ACK) |-> $stable(sda_oe_o));
  // R6: a master NACK frees both lines
  p_nack_free_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == S_TACK && rise_i && sda_i && en_i && !start_i && !stop_i)
      |=> (!sda_oe_o && !scl_oe_o));
  // R11: disabled block never drives
  p_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> (!scl_oe_o && !sda_oe_o));
endmodule

// File: rtl/i2c_tgt_regs.sv
module i2c_tgt_regs
  import i2c_tgt_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic                 re_i,
  input  logic [REG_AW-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  input  logic [FLAG_W-1:0]    set_i,
  input  logic                 rx_push_i,
  input  logic [DATA_W-1:0]    rx_byte_i,
  input  logic                 tx_pop_i,
  output logic                 en_o,
  output logic                 gc_en_o,
  output logic                 force_nack_o,
  output logic [TADDR_W-1:0]   own_addr_o,
  output logic                 rx_full_o,
  output logic                 tx_full_o,
  output logic [DATA_W-1:0]    tx_data_o,
  output logic                 irq_o
);
  localparam int CTRL_W = 3;

  logic [CTRL_W-1:0] ctrl;
  logic [FLAG_W-1:0] flags, ien;
  logic [DATA_W-1:0] rx_data;
  logic wr_flag, wr_data, rd_data;

  assign wr_flag = we_i && addr_i == RA_FLAG;
  assign wr_data = we_i && addr_i == RA_DATA;
  assign rd_data = re_i && addr_i == RA_DATA;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl <= '0; own_addr_o <= '0; flags <= '0; ien <= '0;
      rx_data <= '0; tx_data_o <= '0; rx_full_o <= 1'b0; tx_full_o <= 1'b0;
    end else begin
      if (we_i && addr_i == RA_CTRL) ctrl <= wdata_i[CTRL_W-1:0];
      if (we_i && addr_i == RA_OWN)  own_addr_o <= wdata_i[TADDR_W-1:0];
      if (we_i && addr_i == RA_IEN)  ien <= wdata_i[FLAG_W-1:0];
      flags <= (wr_flag ? (flags & wdata_i[FLAG_W-1:0]) : flags) | set_i;
      if (rx_push_i) begin
        rx_data   <= rx_byte_i;
        rx_full_o <= 1'b1;
      end else if (rd_data) rx_full_o <= 1'b0;
      if (wr_data) begin
        tx_data_o <= wdata_i;
        tx_full_o <= 1'b1;
      end else if (tx_pop_i) tx_full_o <= 1'b0;
    end
  end

  always_comb begin
    unique case (addr_i)
      RA_CTRL: rdata_o = DATA_W'(ctrl);
      RA_OWN:  rdata_o = DATA_W'(own_addr_o);
      RA_FLAG: rdata_o = DATA_W'(flags);
      RA_IEN:  rdata_o = DATA_W'(ien);
      RA_DATA: rdata_o = rx_data;
      default: rdata_o = '0;
    endcase
  end

  assign en_o         = ctrl[C_EN];
  assign gc_en_o      = ctrl[C_GCEN];
  assign force_nack_o = ctrl[C_NACK];
  assign irq_o        = |(flags & ien);

  // R8: write-0 clears unless the same bit is being posted
  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_flag |=> ((flags & ~$past(wdata_i[FLAG_W-1:0]) & ~$past(set_i)) == '0));
  // R3: a received byte marks the register full and posts its flag
  p_rx_flag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push_i |=> (rx_full_o && flags[F_RXD]));
  // R5: a byte moved to the shifter empties the data register
  p_tx_pop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_pop_i && !wr_data) |=> !tx_full_o);
endmodule

// File: rtl/i2c_tgt.sv
module i2c_tgt
  import i2c_tgt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o
);
  logic sda_s, rise, fall, start, stop;
  logic en, gc_en, force_nack, rx_full, tx_full, rx_push, tx_pop;
  logic [TADDR_W-1:0] own_addr;
  logic [DATA_W-1:0]  tx_data, rx_byte;
  logic [FLAG_W-1:0]  set;

  i2c_tgt_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filter (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(rise), .scl_fall_o(fall),
    .start_o(start), .stop_o(stop)
  );

  i2c_tgt_fsm u_fsm (
    .clk_i, .rst_ni, .en_i(en), .gc_en_i(gc_en), .force_nack_i(force_nack),
    .own_addr_i(own_addr), .sda_i(sda_s), .rise_i(rise), .fall_i(fall),
    .start_i(start), .stop_i(stop), .rx_full_i(rx_full), .tx_full_i(tx_full),
    .tx_data_i(tx_data), .rx_push_o(rx_push), .rx_byte_o(rx_byte),
    .tx_pop_o(tx_pop), .set_o(set), .scl_oe_o, .sda_oe_o
  );

  i2c_tgt_regs u_regs (
    .clk_i, .rst_ni, .we_i(reg_we_i), .re_i(reg_re_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .set_i(set),
    .rx_push_i(rx_push), .rx_byte_i(rx_byte), .tx_pop_i(tx_pop),
    .en_o(en), .gc_en_o(gc_en), .force_nack_o(force_nack),
    .own_addr_o(own_addr), .rx_full_o(rx_full), .tx_full_o(tx_full),
    .tx_data_o(tx_data), .irq_o
  );
endmodule

// File: tb/tb_i2c_tgt.sv
module tb_i2c_tgt;
  localparam int CLK_P = 10;
  localparam int QTR   = 8;
  localparam int WDOG  = 150000;
  localparam logic [6:0] OWN = 7'h2C;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic we = 1'b0, re = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic irq, scl_oe, sda_oe;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_bus, sda_bus;
  int vectors = 0, miscompares = 0;

  assign scl_bus = scl_m & ~scl_oe;
  assign sda_bus = sda_m & ~sda_oe;

  always #(CLK_P/2) clk = ~clk;

  i2c_tgt dut (
    .clk_i(clk), .rst_ni, .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq),
    .scl_i(scl_bus), .sda_i(sda_bus), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe)
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic q_wait; repeat (QTR) @(negedge clk); endtask

  task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); re = 1'b1; addr = a; #1 d = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic scl_high; while (!scl_bus) @(negedge clk); endtask

  task automatic m_start;
    sda_m = 1'b1; scl_m = 1'b1; q_wait; sda_m = 1'b0; q_wait; scl_m = 1'b0; q_wait;
  endtask

  task automatic m_stop;
    sda_m = 1'b0; q_wait; scl_m = 1'b1; scl_high; q_wait; sda_m = 1'b1; q_wait;
  endtask

  task automatic m_wbit(input logic b);
    sda_m = b; q_wait; scl_m = 1'b1; scl_high; q_wait; scl_m = 1'b0; q_wait;
  endtask

  task automatic m_rbit(output logic b);
    sda_m = 1'b1; q_wait; scl_m = 1'b1; scl_high; q_wait; b = sda_bus;
    scl_m = 1'b0; q_wait;
  endtask

  task automatic m_wbyte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) m_wbit(v[i]);
  endtask

  task automatic m_rbyte(output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin m_rbit(b); v[i] = b; end
  endtask

  // received byte: check stretch, then read it out to release SCL
  task automatic rx_byte_serviced(input logic [7:0] v, input string req, output logic nak);
    logic [7:0] d;
    m_wbyte(v);
    fork
      m_rbit(nak);
      begin
        repeat (30) @(negedge clk);
        check({req, " SCL held for unread byte"}, scl_bus, 0);
        reg_rd(3'd2, d);
        check({req, " flag bit1"}, d[1], 1);
        reg_rd(3'd4, d);
        check({req, " received byte"}, d, v);
      end
    join
  endtask

  task automatic t_reset;
    logic [7:0] d;
    reg_rd(3'd2, d); check("R1 flags", d, 0);
    reg_rd(3'd0, d); check("R1 control", d, 0);
    check("R1 irq", irq, 0);
    check("R1 lines free", {scl_bus, sda_bus}, 2'b11);
  endtask

  task automatic t_config;
    logic [7:0] d;
    reg_wr(3'd1, {1'b0, OWN});
    reg_wr(3'd3, 8'h01);
    reg_wr(3'd0, 8'h04);
    reg_rd(3'd1, d); check("R2 own address readback", d, OWN);
  endtask

  task automatic t_write;
    logic b, nak;
    logic [7:0] d;
    m_start; m_wbyte({OWN, 1'b0}); m_rbit(b);
    check("R2 address ACK", b, 0);
    reg_rd(3'd2, d); check("R2 address flag", d, 8'h01);
    check("R9 irq on enabled flag", irq, 1);
    reg_wr(3'd3, 8'h00);
    check("R9 irq masked", irq, 0);
    reg_wr(3'd3, 8'h01);
    reg_wr(3'd2, 8'hFE);
    reg_rd(3'd2, d); check("R8 clear bit0", d, 0);
    rx_byte_serviced(8'hA5, "R3", nak);
    check("R3 ACK after read", nak, 0);
    m_stop;
    reg_rd(3'd2, d); check("R7 stop flag", d, 8'h12);
    reg_wr(3'd2, 8'h00);
  endtask

  task automatic t_nomatch;
    logic b;
    logic [7:0] d;
    m_start; m_wbyte({7'h15, 1'b0}); m_rbit(b);
    check("R2 foreign address no ACK", b, 1);
    m_stop;
    reg_rd(3'd2, d); check("R2 no address flag", d, 8'h10);
    reg_wr(3'd2, 8'h00);
  endtask

  task automatic t_force_nack;
    logic b, nak;
    m_start;
    reg_wr(3'd0, 8'h05);
    m_wbyte({OWN, 1'b0}); m_rbit(b);
    check("R4 address still ACKed", b, 0);
    rx_byte_serviced(8'h77, "R4", nak);
    check("R4 data NACKed", nak, 1);
    m_stop;
    reg_wr(3'd0, 8'h04);
    reg_wr(3'd2, 8'h00);
  endtask

  task automatic t_read;
    logic b;
    logic [7:0] d, v;
    m_start; m_wbyte({OWN, 1'b1}); m_rbit(b);
    check("R5 read address ACK", b, 0);
    repeat (20) @(negedge clk);
    check("R5 SCL held for empty data", scl_bus, 0);
    reg_rd(3'd2, d); check("R5 flags bits 5,3,0", d, 8'h29);
    reg_wr(3'd2, 8'hF7);
    reg_rd(3'd2, d); check("R8 clear only bit3", d, 8'h21);
    reg_wr(3'd2, 8'hFF);
    reg_rd(3'd2, d); check("R8 write-1 keeps", d, 8'h21);
    fork
      m_rbyte(v);
      begin repeat (30) @(negedge clk); reg_wr(3'd4, 8'h3C); end
    join
    check("R5 first byte MSB first", v, 8'h3C);
    reg_rd(3'd2, d); check("R5 empty and sent flags", d & 8'h0C, 8'h0C);
    m_wbit(1'b0);
    reg_wr(3'd2, 8'h00);
    fork
      m_rbyte(v);
      begin repeat (30) @(negedge clk);
        check("R5 SCL held before second byte", scl_bus, 0);
        reg_wr(3'd4, 8'hC3);
      end
    join
    check("R5 second byte", v, 8'hC3);
    m_wbit(1'b1);
    sda_m = 1'b1; scl_m = 1'b1;
    repeat (20) @(negedge clk);
    check("R6 lines free after NACK", {scl_bus, sda_bus}, 2'b11);
    scl_m = 1'b0; q_wait;
    m_stop;
    reg_wr(3'd2, 8'h00);
  endtask

  task automatic t_gcall;
    logic b;
    logic [7:0] d;
    m_start; m_wbyte(8'h00); m_rbit(b);
    check("R10 general call off no ACK", b, 1);
    m_stop;
    reg_rd(3'd2, d); check("R10 no gc flag", d, 8'h10);
    reg_wr(3'd2, 8'h00);
    reg_wr(3'd0, 8'h06);
    m_start; m_wbyte(8'h00); m_rbit(b);
    check("R10 general call ACK", b, 0);
    reg_rd(3'd2, d); check("R10 gc and address flags", d, 8'h41);
    m_stop;
    reg_wr(3'd2, 8'h00);
  endtask

  task automatic t_disabled;
    logic b;
    logic [7:0] d;
    reg_wr(3'd0, 8'h00);
    reg_wr(3'd3, 8'h7F);
    m_start; m_wbyte({OWN, 1'b0}); m_rbit(b);
    check("R11 no ACK when disabled", b, 1);
    m_stop;
    reg_rd(3'd2, d); check("R11 no flags when disabled", d, 0);
    check("R11 irq low", irq, 0);
  endtask

  initial begin : watchdog
    repeat (WDOG) @(posedge clk);
    vectors++; miscompares++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_config;
    t_write;
    t_nomatch;
    t_force_nack;
    t_read;
    t_gcall;
    t_disabled;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule